// File: doc/BRIEF.md
# IOMMU Stream Match and Route Table

This block sorts incoming DMA transactions by their stream identifier. It keeps a fixed set of match slots. Each slot holds an ID, a don't-care mask and a valid flag. Each slot is paired, by index, with a routing entry that holds a route type and a context bank number. A lookup compares the presented stream ID against every valid slot in the same cycle. One cycle later the block answers with one of these outcomes: bypass, translate through a given context bank, unmatched fault, fault caused by the routing entry itself, or conflict.

Software fills the table through a single write port. One address bit selects between the match slots and the routing entries, and the low address bits give the slot index. A stream that firmware first pointed at an identity-mapped bypass route can later be moved onto a translating context bank. This is done by rewriting only its routing entry, so the match slot is never touched and no second slot is taken for the same device.

Top module: `smt_table`

## Requirements
- R1: A valid slot hits when `((lk_sid ^ id) & ~mask) == 0`. Bits set in the mask are don't-care, and every other bit must be equal.
- R2: A slot whose valid flag is clear never hits, even if its ID and mask would match.
- R3: A single hit on a slot whose routing type is 2 (translate) answers kind 2 and puts the paired entry's context bank number on `rsp_cb`.
- R4: A single hit on a slot whose routing type is 1 (bypass) answers kind 1 with `rsp_cb` = 0.
- R5: A single hit on a slot whose routing type is 0 (fault) or 3 (reserved) answers kind 0 (entry fault) with `rsp_cb` = 0.
- R6: A lookup that hits two or more valid slots answers kind 4 (conflict), with `rsp_conflict` = 1 and `rsp_cb` = 0. In every other case `rsp_conflict` is 0.
- R7: A lookup that hits no valid slot answers kind 3 (unmatched).
- R8: Rewriting only a slot's routing entry changes the answer for streams that hit that slot, and the slot's matching stays as it was.
- R9: A write is seen by lookups presented from the next cycle on. A lookup in the same cycle as the write sees the old contents. `rsp_valid` and the result appear one cycle after `lk_valid`.
- R10: After reset every slot is invalid, every routing entry has type 0 (fault), and `rsp_valid` is 0.
- R11: Write encoding:
  - `wr_sel` = 0 writes a match slot, with `wr_data[15:0]` = ID, `[31:16]` = mask and `[32]` = valid.
  - `wr_sel` = 1 writes a routing entry, with `wr_data[1:0]` = type and `[5:2]` = context bank.
  - `wr_idx` selects the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 = match slot, 1 = routing entry |
| wr_idx | input | 4 | Slot index |
| wr_data | input | 33 | Write data (see R11) |
| lk_valid | input | 1 | Lookup request |
| lk_sid | input | 16 | Stream ID to classify |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_kind | output | 3 | 0 entry fault, 1 bypass, 2 translate, 3 unmatched, 4 conflict |
| rsp_cb | output | 4 | Context bank number for translate, otherwise 0 |
| rsp_conflict | output | 1 | Multiple-hit indication |

## Verification
The bench targets slots whose masks overlap, so that a single stream can hit two entries. A design that picked the lowest-index hit instead of raising a conflict would route such a stream silently. Invalid slots are loaded with IDs that would otherwise match; a design that ignored the valid flag would report a hit where unmatched is expected. A write and a lookup are issued in the same cycle to catch a design that forwards write data into the current lookup. The route-only repoint checks that the answer follows the new routing entry while matching is unaffected. A design that matched exactly and ignored the mask would return unmatched on the masked-bit variants.

// File: rtl/smt_pkg.sv
package smt_pkg;

    localparam int unsigned DEF_SLOTS = 16;
    localparam int unsigned DEF_SID_W = 16;
    localparam int unsigned DEF_CB_W  = 4;

    typedef enum logic [1:0] {
        RT_FAULT  = 2'd0,
        RT_BYPASS = 2'd1,
        RT_XLATE  = 2'd2,
        RT_RSVD   = 2'd3
    } route_t;

    typedef enum logic [2:0] {
        K_ENTRY_FAULT = 3'd0,
        K_BYPASS      = 3'd1,
        K_XLATE       = 3'd2,
        K_UNMATCHED   = 3'd3,
        K_CONFLICT    = 3'd4
    } kind_t;

    function automatic kind_t kind_of_route(route_t r);
        case (r)
            RT_BYPASS: return K_BYPASS;
            RT_XLATE:  return K_XLATE;
            default:   return K_ENTRY_FAULT;
        endcase
    endfunction

endpackage

// File: rtl/smt_slot_bank.sv
module smt_slot_bank
    import smt_pkg::*;
#(
    parameter int unsigned NSLOT  = DEF_SLOTS,
    parameter int unsigned SID_W  = DEF_SID_W,
    parameter int unsigned CB_W   = DEF_CB_W,
    parameter int unsigned IDX_W  = $clog2(NSLOT),
    parameter int unsigned DATA_W = 2 * SID_W + 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic                        wr_sel,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [SID_W-1:0]            lk_sid,
    output logic [NSLOT-1:0]            hit_vec,
    output logic [NSLOT-1:0][1:0]       rt_vec,
    output logic [NSLOT-1:0][CB_W-1:0]  cb_vec
);

    logic [NSLOT-1:0]             v_q;
    logic [NSLOT-1:0][SID_W-1:0]  id_q;
    logic [NSLOT-1:0][SID_W-1:0]  mask_q;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic sel_me;
        assign sel_me = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q[g]    <= 1'b0;
                id_q[g]   <= '0;
                mask_q[g] <= '0;
                rt_vec[g] <= RT_FAULT;
                cb_vec[g] <= '0;
            end else if (sel_me) begin
                if (!wr_sel) begin
                    id_q[g]   <= wr_data[SID_W-1:0];
                    mask_q[g] <= wr_data[2*SID_W-1:SID_W];
                    v_q[g]    <= wr_data[2*SID_W];
                end else begin
                    rt_vec[g] <= wr_data[1:0];
                    cb_vec[g] <= wr_data[2+CB_W-1:2];
                end
            end
        end

        assign hit_vec[g] = v_q[g] && (((lk_sid ^ id_q[g]) & ~mask_q[g]) == '0);
    end

endmodule

// File: rtl/smt_resolve.sv
module smt_resolve
    import smt_pkg::*;
#(
    parameter int unsigned NSLOT = DEF_SLOTS,
    parameter int unsigned CB_W  = DEF_CB_W
) (
    input  logic [NSLOT-1:0]            hit_vec,
    input  logic [NSLOT-1:0][1:0]       rt_vec,
    input  logic [NSLOT-1:0][CB_W-1:0]  cb_vec,
    output kind_t                       kind,
    output logic [CB_W-1:0]             cb,
    output logic                        conflict
);

    logic              any_hit;
    logic              multi_hit;
    route_t            sel_rt;
    logic [CB_W-1:0]   sel_cb;

    always_comb begin
        any_hit   = |hit_vec;
        multi_hit = |(hit_vec & (hit_vec - NSLOT'(1)));
        sel_rt    = RT_FAULT;
        sel_cb    = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel_rt = route_t'(rt_vec[i]);
                sel_cb = cb_vec[i];
            end
        end
    end

    always_comb begin
        conflict = 1'b0;
        cb       = '0;
        if (!any_hit) begin
            kind = K_UNMATCHED;
        end else if (multi_hit) begin
            kind     = K_CONFLICT;
            conflict = 1'b1;
        end else begin
            kind = kind_of_route(sel_rt);
            if (sel_rt == RT_XLATE) cb = sel_cb;
        end
    end

endmodule

// File: rtl/smt_table.sv
module smt_table
    import smt_pkg::*;
#(
    parameter int unsigned NSLOT  = DEF_SLOTS,
    parameter int unsigned SID_W  = DEF_SID_W,
    parameter int unsigned CB_W   = DEF_CB_W,
    parameter int unsigned IDX_W  = $clog2(NSLOT),
    parameter int unsigned DATA_W = 2 * SID_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               lk_valid,
    input  logic [SID_W-1:0]   lk_sid,
    output logic               rsp_valid,
    output logic [2:0]         rsp_kind,
    output logic [CB_W-1:0]    rsp_cb,
    output logic               rsp_conflict
);

    logic [NSLOT-1:0]            hit_vec;
    logic [NSLOT-1:0][1:0]       rt_vec;
    logic [NSLOT-1:0][CB_W-1:0]  cb_vec;
    kind_t                       nx_kind;
    logic [CB_W-1:0]             nx_cb;
    logic                        nx_conflict;

    smt_slot_bank #(
        .NSLOT(NSLOT), .SID_W(SID_W), .CB_W(CB_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
    ) u_bank (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
        .lk_sid(lk_sid),
        .hit_vec(hit_vec), .rt_vec(rt_vec), .cb_vec(cb_vec)
    );

    smt_resolve #(.NSLOT(NSLOT), .CB_W(CB_W)) u_resolve (
        .hit_vec(hit_vec), .rt_vec(rt_vec), .cb_vec(cb_vec),
        .kind(nx_kind), .cb(nx_cb), .conflict(nx_conflict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_kind     <= K_UNMATCHED;
            rsp_cb       <= '0;
            rsp_conflict <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            if (lk_valid) begin
                rsp_kind     <= nx_kind;
                rsp_cb       <= nx_cb;
                rsp_conflict <= nx_conflict;
            end
        end
    end

endmodule

// File: rtl/smt_table_chk.sv
module smt_table_chk #(
    parameter int unsigned NSLOT = 16,
    parameter int unsigned CB_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic [NSLOT-1:0]  hit_vec,
    input logic              rsp_valid,
    input logic [2:0]        rsp_kind,
    input logic [CB_W-1:0]   rsp_cb,
    input logic              rsp_conflict
);

    a_r9_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    a_r9_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);

    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> !rsp_valid);

    a_r6_multi_hit_conflict: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && $countones(hit_vec) > 1) |=> (rsp_conflict && rsp_kind == 3'd4 && rsp_cb == '0));

    a_r7_no_hit_unmatched: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && hit_vec == '0) |=> (rsp_kind == 3'd3 && !rsp_conflict));

    a_r6_single_hit_no_conflict: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && $onehot0(hit_vec)) |=> !rsp_conflict);

    a_r5_nonxlate_cb_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind != 3'd2) |-> rsp_cb == '0);

endmodule

bind smt_table smt_table_chk #(.NSLOT(NSLOT), .CB_W(CB_W)) u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .hit_vec(hit_vec),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_cb(rsp_cb),
    .rsp_conflict(rsp_conflict)
);

// File: tb/smt_table_tb.sv
module smt_table_tb_top;

    localparam int NS = 16;
    localparam int SW = 16;
    localparam int CW = 4;
    localparam int DW = 2 * SW + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [3:0]    wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic          lk_valid = 1'b0;
    logic [SW-1:0] lk_sid = '0;
    logic          rsp_valid;
    logic [2:0]    rsp_kind;
    logic [CW-1:0] rsp_cb;
    logic          rsp_conflict;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [SW-1:0] m_id   [NS];
    logic [SW-1:0] m_mask [NS];
    logic          m_v    [NS];
    logic [1:0]    m_rt   [NS];
    logic [CW-1:0] m_cb   [NS];

    always #5 clk = ~clk;

    smt_table dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wr_data(wr_data), .lk_valid(lk_valid), .lk_sid(lk_sid),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_cb(rsp_cb),
        .rsp_conflict(rsp_conflict)
    );

    function automatic logic [6:0] predict(logic [SW-1:0] sid);
        int n = 0;
        int hi = 0;
        for (int i = 0; i < NS; i++) begin
            if (m_v[i] && (((sid ^ m_id[i]) & ~m_mask[i]) == '0)) begin
                n++;
                hi = i;
            end
        end
        if (n == 0) return {3'd3, 4'd0};
        if (n > 1)  return {3'd4, 4'd0};
        case (m_rt[hi])
            2'd1:    return {3'd1, 4'd0};
            2'd2:    return {3'd2, m_cb[hi]};
            default: return {3'd0, 4'd0};
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] k);
        case (k)
            3'd0: return "R5";
            3'd1: return "R4";
            3'd2: return "R3";
            3'd3: return "R7";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void apply(bit sel, int idx, logic [DW-1:0] d);
        if (!sel) begin
            m_id[idx]   = d[SW-1:0];
            m_mask[idx] = d[2*SW-1:SW];
            m_v[idx]    = d[2*SW];
        end else begin
            m_rt[idx] = d[1:0];
            m_cb[idx] = d[5:2];
        end
    endfunction

    task automatic wr(bit sel, int idx, logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_idx = 4'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        apply(sel, idx, d);
    endtask

    function automatic logic [DW-1:0] slot_word(bit v, logic [SW-1:0] mask, logic [SW-1:0] id);
        return {v, mask, id};
    endfunction

    function automatic logic [DW-1:0] route_word(logic [1:0] t, logic [CW-1:0] cb);
        return DW'({cb, t});
    endfunction

    task automatic look(logic [SW-1:0] sid, string req);
        logic [6:0] e;
        @(negedge clk);
        lk_valid = 1'b1; lk_sid = sid;
        e = predict(sid);
        @(negedge clk);
        lk_valid = 1'b0;
        check(req, {31'd0, rsp_valid}, 32'd1);
        check(req, {29'd0, rsp_kind}, {29'd0, e[6:4]});
        check(req, {28'd0, rsp_cb}, {28'd0, e[3:0]});
        check(req, {31'd0, rsp_conflict}, {31'd0, e[6:4] == 3'd4});
    endtask

    task automatic clear_table();
        for (int i = 0; i < NS; i++) begin
            wr(0, i, '0);
            wr(1, i, '0);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [6:0] e;
        void'($urandom(32'd1234));
        for (int i = 0; i < NS; i++) begin
            m_id[i] = '0; m_mask[i] = '0; m_v[i] = 1'b0; m_rt[i] = 2'd0; m_cb[i] = '0;
        end
        repeat (3) @(negedge clk);
        check("R10", {31'd0, rsp_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R10", {31'd0, rsp_valid}, 32'd0);

        // R10: reset table has no valid slot, so any stream is unmatched
        look(16'h0000, "R10");
        look(16'h1C00, "R10");
        // R10: validating a slot without a route write leaves fault type
        wr(0, 3, slot_word(1'b1, 16'h0000, 16'h0123));
        look(16'h0123, "R10");

        // R1: masked compare, mask 0x0002 makes bit 1 don't-care
        wr(0, 8, slot_word(1'b1, 16'h0002, 16'h1C00));
        wr(1, 8, route_word(2'd1, 4'd0));
        look(16'h1C00, "R1");
        look(16'h1C02, "R1");
        look(16'h1C01, "R1");
        look(16'h1C04, "R1");

        // R2: invalid slot with a matching id stays silent
        wr(0, 9, slot_word(1'b0, 16'h0000, 16'h0555));
        wr(1, 9, route_word(2'd2, 4'd7));
        look(16'h0555, "R2");

        // R8: repoint slot 8 from bypass to translate, match slot untouched
        wr(1, 8, route_word(2'd2, 4'd9));
        look(16'h1C02, "R8");
        look(16'h1C01, "R8");

        // R5: reserved type behaves as fault
        wr(1, 8, route_word(2'd3, 4'd6));
        look(16'h1C00, "R5");

        // R6: overlapping slot 10 catches 0x1C00 too
        wr(0, 10, slot_word(1'b1, 16'h00FF, 16'h1C00));
        wr(1, 10, route_word(2'd2, 4'd2));
        look(16'h1C02, "R6");
        look(16'h1C40, "R3");

        // R9: write and lookup in the same cycle see old contents
        wr(1, 10, route_word(2'd1, 4'd0));
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_idx = 4'd10; wr_data = route_word(2'd2, 4'd5);
        lk_valid = 1'b1; lk_sid = 16'h1C40;
        e = predict(16'h1C40);
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
        apply(1, 10, route_word(2'd2, 4'd5));
        check("R9", {29'd0, rsp_kind}, {29'd0, e[6:4]});
        check("R9", {31'd0, rsp_valid}, 32'd1);
        @(negedge clk);
        check("R9", {31'd0, rsp_valid}, 32'd0);
        look(16'h1C40, "R9");

        // R11 with random tables
        for (int pass = 0; pass < 4; pass++) begin
            clear_table();
            for (int i = 0; i < NS; i++) begin
                logic [SW-1:0] id;
                logic [SW-1:0] mk;
                id = 16'h1C00 | SW'($urandom & 32'h3F);
                mk = ($urandom % 3 == 0) ? SW'($urandom & 32'h3) : '0;
                wr(0, i, slot_word(1'(($urandom % 4) != 0), mk, id));
                wr(1, i, route_word(2'($urandom), 4'($urandom)));
            end
            for (int n = 0; n < 80; n++) begin
                logic [SW-1:0] s;
                s = 16'h1C00 | SW'($urandom & 32'h7F);
                e = predict(s);
                look(s, {"R11/", tag_of(e[6:4])});
            end
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule